// File: doc/BRIEF.md
# PCI Target Burst Address Tracker

This block holds the address side of a 32-bit PCI target. The target shares one bus between address and data. On the first clock of a transaction the block latches the bus value and the command nibble, and it sorts the cycle into one of five types: I/O, memory, configuration, special, or any other command. It then checks whether the latched address falls inside its own memory window or its own I/O window. Each window is set by a base and a mask that the register backend supplies. No central decoder is involved.

For a memory cycle the two low address bits are not address. They select the burst ordering. With `00` the block runs a linear burst and moves its dword address forward on every data phase that completes. With any other value the block takes part in the first data phase only. After that it stops claiming the cycle and waits for the initiator to release the bus. I/O, configuration and special cycles keep their address fixed for the whole transaction. The backend reads the current address, the cycle type, the hit flag and the burst flag each clock.

Top module: `pci_burst_tracker`

## Requirements
- R1: At reset, and at any time no transaction is open, `active`, `hit` and `burst` are 0 and `cyc_type` is 0 (none). Reset also clears `cur_addr` to 0.
- R2: If `frame_n` is low at a clock edge while no transaction is open, that edge is the address phase. After the edge `active` is 1 and `cur_addr` holds the bus value. For memory cycles bits 1..0 of `cur_addr` are forced to 00.
- R3: `cyc_type` comes from `cbe_n` at the address phase. The mapping is: 0010 or 0011 gives 1 (I/O); 0110 or 0111 gives 2 (memory); 1010 or 1011 gives 3 (configuration); 0001 gives 4 (special); every other nibble gives 5 (other).
- R4: During the data phases of a memory cycle, `hit` is 1 exactly when `((start ^ mem_base) & mem_mask)` is zero, with bits 1..0 of the compare ignored.
- R5: During the data phases of an I/O cycle, `hit` is 1 exactly when `((start ^ io_base) & io_mask)` is zero over all 32 bits, so the compare is at byte level. For configuration, special and other cycles `hit` stays 0.
- R6: `burst` is 1 for a memory cycle whose address bits 1..0 were 00 at the address phase. It is 0 for every other cycle.
- R7: In a linear memory burst, each clock with `irdy_n`, `trdy_n` and `frame_n` all low adds 4 to `cur_addr`, wrapping at 2^32. A clock where `irdy_n` or `trdy_n` is high leaves `cur_addr` unchanged. The bus value during data phases is ignored.
- R8: A data phase that completes with `frame_n` high is the last phase. On the next clock `active` is 0.
- R9: In a memory cycle with bits 1..0 not 00, the first completed data phase with `frame_n` still low ends the claim. From then on `hit` is 0 and `cur_addr` holds. `active` stays 1 until an edge where `frame_n` is high and either `irdy_n` is high or `trdy_n` is low.
- R10: For I/O, configuration, special and other cycles, `cur_addr` keeps the address-phase value through every data phase.
- R11: `hit` is computed from the address latched at the address phase. It does not change while a burst counter moves out of the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Transaction framing from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command nibble during the address phase |
| mem_base | input | 32 | Memory window base |
| mem_mask | input | 32 | Memory window compare mask |
| io_base | input | 32 | I/O window base |
| io_mask | input | 32 | I/O window compare mask |
| active | output | 1 | A transaction is open |
| hit | output | 1 | The target claims the current cycle |
| cyc_type | output | 3 | Cycle class (encoding in R3) |
| cur_addr | output | 32 | Current target address |
| burst | output | 1 | Linear memory burst in progress |

## Verification
The assertions run on every clock and check these rules:
- The outputs are quiet when no transaction is open.
- A hit only ever goes with an I/O or memory cycle, and the burst flag only with a memory cycle.
- The address moves by exactly one dword on each completed linear phase and holds during wait states and non-memory cycles.
- A completed phase with framing released closes the transaction.
- The claim drops after the first phase of a non-linear memory cycle.

Some behaviour can only be shown by the bench scenarios:
- the exact address latched at the address phase;
- the full command mapping;
- window decisions against given bases and masks, including byte-level I/O misses and a burst that crosses its window edge;
- the drain of a non-linear cycle;
- back-to-back transactions.

// File: rtl/pci_trk_pkg.sv
// Package: shared types for the PCI target burst address tracker.
// Assumes a 4-bit command nibble and a 3-bit cycle class at the top ports.
package pci_trk_pkg;

    typedef enum logic [2:0] {
        CYC_NONE    = 3'd0,
        CYC_IO      = 3'd1,
        CYC_MEM     = 3'd2,
        CYC_CFG     = 3'd3,
        CYC_SPECIAL = 3'd4,
        CYC_OTHER   = 3'd5
    } cyc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2
    } trk_state_t;

endpackage

// File: rtl/pci_trk_cmd_decode.sv
// Module: pci_trk_cmd_decode
// Maps the address-phase command nibble to a cycle class. The logic is
// purely combinational and assumes the nibble is already in active-low
// bus form.
module pci_trk_cmd_decode
    import pci_trk_pkg::*;
(
    input  logic [3:0] cmd_n,
    output cyc_t       kind
);

    // Classify the command nibble; unlisted codes fall into CYC_OTHER.
    always_comb begin
        case (cmd_n)
            4'b0010, 4'b0011: kind = CYC_IO;
            4'b0110, 4'b0111: kind = CYC_MEM;
            4'b1010, 4'b1011: kind = CYC_CFG;
            4'b0001:          kind = CYC_SPECIAL;
            default:          kind = CYC_OTHER;
        endcase
    end

endmodule

// File: rtl/pci_trk_window.sv
// Module: pci_trk_window
// Base/mask window compare. IGN_LO low bits are left out of the compare,
// so a memory window can ignore the burst-order bits. Combinational.
module pci_trk_window #(
    parameter int ADDR_W = 32,
    parameter int IGN_LO = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              match
);

    logic [ADDR_W-1:0] eff_mask;

    // Build the effective mask, clearing the ignored low bits when asked.
    generate
        if (IGN_LO > 0) begin : g_ign
            localparam logic [ADDR_W-1:0] LO_CLR = ~((ADDR_W'(1) << IGN_LO) - ADDR_W'(1));
            assign eff_mask = mask & LO_CLR;
        end else begin : g_full
            assign eff_mask = mask;
        end
    endgenerate

    // Match when no compared bit differs from the base.
    assign match = ((addr ^ base) & eff_mask) == '0;

endmodule

// File: rtl/pci_trk_addr_ctr.sv
// Module: pci_trk_addr_ctr
// Current-address register. It loads at the address phase and moves
// forward one dword per step. It assumes load and step never come in the
// same clock; load wins if they do.
module pci_trk_addr_ctr #(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << LANE_W;

    // Hold, load or advance the address by one dword stride.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + STRIDE;
        end
    end

endmodule

// File: rtl/pci_burst_tracker.sv
// Module: pci_burst_tracker (top)
// Tracks address and data phases for one PCI-style target on a multiplexed
// bus. It assumes a single initiator owns the bus whenever frame_n is low.
// It also assumes the window bases and masks stay steady while a
// transaction is open.
module pci_burst_tracker
    import pci_trk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] mem_mask,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] io_mask,
    output logic              active,
    output logic              hit,
    output logic [2:0]        cyc_type,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst
);

    localparam int LANE_W = 2;
    localparam logic [ADDR_W-1:0] LANE_CLR = ~((ADDR_W'(1) << LANE_W) - ADDR_W'(1));

    trk_state_t        st_q;
    cyc_t              kind_q;
    cyc_t              kind_dec;
    logic              linear_q;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] load_val;
    logic              addr_phase;
    logic              phase_done;
    logic              step;
    logic              mem_match;
    logic              io_match;

    pci_trk_cmd_decode u_dec (
        .cmd_n (cbe_n),
        .kind  (kind_dec)
    );

    // Bus events seen this clock.
    always_comb begin
        addr_phase = (st_q == ST_IDLE) && !frame_n;
        phase_done = !irdy_n && !trdy_n;
        step       = (st_q == ST_XFER) && phase_done && !frame_n
                     && (kind_q == CYC_MEM) && linear_q;
        load_val   = (kind_dec == CYC_MEM) ? (ad & LANE_CLR) : ad;
    end

    pci_trk_addr_ctr #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_phase),
        .load_val (load_val),
        .step     (step),
        .addr     (cur_addr)
    );

    // Transaction state: idle, claiming data phases, or draining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (addr_phase) st_q <= ST_XFER;
                ST_XFER: begin
                    if (phase_done && frame_n) begin
                        st_q <= ST_IDLE;
                    end else if (phase_done && (kind_q == CYC_MEM) && !linear_q) begin
                        st_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: if (frame_n && (irdy_n || !trdy_n)) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Address-phase captures: cycle class, ordering and start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= CYC_NONE;
            linear_q <= 1'b0;
            start_q  <= '0;
        end else if (addr_phase) begin
            kind_q   <= kind_dec;
            linear_q <= (kind_dec == CYC_MEM) && (ad[LANE_W-1:0] == '0);
            start_q  <= ad;
        end else if ((st_q != ST_IDLE) && frame_n
                     && ((st_q == ST_XFER) ? phase_done : (irdy_n || !trdy_n))) begin
            kind_q   <= CYC_NONE;
            linear_q <= 1'b0;
        end
    end

    pci_trk_window #(
        .ADDR_W (ADDR_W),
        .IGN_LO (LANE_W)
    ) u_mem_win (
        .addr  (start_q),
        .base  (mem_base),
        .mask  (mem_mask),
        .match (mem_match)
    );

    pci_trk_window #(
        .ADDR_W (ADDR_W),
        .IGN_LO (0)
    ) u_io_win (
        .addr  (start_q),
        .base  (io_base),
        .mask  (io_mask),
        .match (io_match)
    );

    // Outputs to the register backend.
    always_comb begin
        active   = (st_q != ST_IDLE);
        hit      = (st_q == ST_XFER)
                   && (((kind_q == CYC_MEM) && mem_match) || ((kind_q == CYC_IO) && io_match));
        cyc_type = kind_q;
        burst    = linear_q;
    end

endmodule

// File: rtl/pci_burst_tracker_chk.sv
// Module: pci_burst_tracker_chk
// Assertion checker bound to pci_burst_tracker. It watches only the top
// ports and assumes the synchronous active-low reset.
module pci_burst_tracker_chk
    import pci_trk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              trdy_n,
    input logic              active,
    input logic              hit,
    input logic [2:0]        cyc_type,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              burst
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!hit && !burst && cyc_type == CYC_NONE));

    assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !frame_n) |=> active);

    assert_hit_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cyc_type == CYC_MEM || cyc_type == CYC_IO));

    assert_burst_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        burst |-> (cyc_type == CYC_MEM));

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && burst && !frame_n && !irdy_n && !trdy_n)
        |=> (cur_addr == $past(cur_addr) + STRIDE));

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (irdy_n || trdy_n)) |=> $stable(cur_addr));

    assert_last_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && frame_n && !irdy_n && !trdy_n) |=> !active);

    assert_drop_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cyc_type == CYC_MEM && !burst && !frame_n && !irdy_n && !trdy_n)
        |=> (!hit && $stable(cur_addr)));

    assert_fixed_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cyc_type != CYC_MEM) |=> $stable(cur_addr));

endmodule

bind pci_burst_tracker pci_burst_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .trdy_n   (trdy_n),
    .active   (active),
    .hit      (hit),
    .cyc_type (cyc_type),
    .cur_addr (cur_addr),
    .burst    (burst)
);

// File: tb/pci_burst_tracker_test.sv
// Bench for pci_burst_tracker. A behavioural reference model is compared
// on every clock, and directed checks cover the listed requirements.
module pci_burst_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] mem_base = 32'h1000_0000;
    logic [31:0] mem_mask = 32'hFFFF_F000;
    logic [31:0] io_base  = 32'h0000_03F8;
    logic [31:0] io_mask  = 32'hFFFF_FFF8;
    logic        active, hit, burst;
    logic [2:0]  cyc_type;
    logic [31:0] cur_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pci_burst_tracker uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .ad(ad), .cbe_n(cbe_n), .mem_base(mem_base), .mem_mask(mem_mask),
        .io_base(io_base), .io_mask(io_mask), .active(active), .hit(hit),
        .cyc_type(cyc_type), .cur_addr(cur_addr), .burst(burst)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state
    int          m_st = 0;      // 0 idle, 1 claiming, 2 draining
    int          m_kind = 0;
    bit          m_lin = 0;
    logic [31:0] m_start = '0;
    logic [31:0] m_addr = '0;

    function automatic int classify(input logic [3:0] c);
        if (c == 4'b0010 || c == 4'b0011) return 1;
        if (c == 4'b0110 || c == 4'b0111) return 2;
        if (c == 4'b1010 || c == 4'b1011) return 3;
        if (c == 4'b0001) return 4;
        return 5;
    endfunction

    function automatic bit model_hit();
        if (m_st != 1) return 0;
        if (m_kind == 2) return ((m_start ^ mem_base) & mem_mask & 32'hFFFF_FFFC) == 0;
        if (m_kind == 1) return ((m_start ^ io_base) & io_mask) == 0;
        return 0;
    endfunction

    // Advance the model at each edge, then compare the outputs 2 ns later.
    always @(posedge clk) begin
        bool_step();
        #2;
        chk("R8 active", {31'd0, active}, {31'd0, m_st != 0});
        chk("R3 cyc_type", {29'd0, cyc_type}, m_kind);
        chk("R7 cur_addr", cur_addr, m_addr);
        chk("R4 hit", {31'd0, hit}, {31'd0, model_hit()});
        chk("R6 burst", {31'd0, burst}, {31'd0, m_lin});
    end

    task automatic bool_step();
        bit xfer;
        xfer = !irdy_n && !trdy_n;
        if (!rst_n) begin
            m_st = 0; m_kind = 0; m_lin = 0; m_start = '0; m_addr = '0;
        end else if (m_st == 0) begin
            if (!frame_n) begin
                m_st = 1;
                m_kind = classify(cbe_n);
                m_start = ad;
                m_lin = (m_kind == 2) && (ad[1:0] == 2'b00);
                m_addr = (m_kind == 2) ? {ad[31:2], 2'b00} : ad;
            end
        end else if (m_st == 1) begin
            if (xfer && frame_n) begin
                m_st = 0; m_kind = 0; m_lin = 0;
            end else if (xfer && m_kind == 2) begin
                if (m_lin) m_addr = m_addr + 4;
                else m_st = 2;
            end
        end else begin
            if (frame_n && (irdy_n || !trdy_n)) begin
                m_st = 0; m_kind = 0; m_lin = 0;
            end
        end
    endtask

    task automatic addr_phase(input logic [31:0] a, input logic [3:0] c);
        @(negedge clk);
        frame_n = 0; irdy_n = 1; trdy_n = 1; ad = a; cbe_n = c;
    endtask

    task automatic data_phase(input bit last, input bit stall);
        @(negedge clk);
        frame_n = last; irdy_n = stall; trdy_n = 0;
        ad = 32'hDEAD_0000 ^ ad; cbe_n = 4'h0;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        frame_n = 1; irdy_n = 1; trdy_n = 1; cbe_n = 4'hF;
    endtask

    task automatic settle();
        @(posedge clk);
        #3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        settle();
        // R1 reset state
        chk("R1 active", {31'd0, active}, 0);
        chk("R1 hit", {31'd0, hit}, 0);
        chk("R1 cur_addr", cur_addr, 0);
        chk("R1 cyc_type", {29'd0, cyc_type}, 0);
        @(negedge clk); rst_n = 1;

        // Linear memory burst inside the window
        addr_phase(32'h1000_0100, 4'b0111); settle();
        chk("R2 cur_addr", cur_addr, 32'h1000_0100);
        chk("R2 active", {31'd0, active}, 1);
        chk("R4 hit in window", {31'd0, hit}, 1);
        chk("R6 burst", {31'd0, burst}, 1);
        data_phase(0, 0);
        data_phase(0, 1); settle();
        chk("R7 wait holds", cur_addr, 32'h1000_0104);
        data_phase(0, 0); settle();
        chk("R7 step", cur_addr, 32'h1000_0108);
        data_phase(1, 0); settle();
        chk("R8 idle after last", {31'd0, active}, 0);
        chk("R1 quiet idle", {31'd0, hit | burst}, 0);

        // Burst crossing the window edge, then a back-to-back start
        addr_phase(32'h1000_0FF8, 4'b0110);
        data_phase(0, 0);
        data_phase(0, 0); settle();
        chk("R11 cur_addr past window", cur_addr, 32'h1000_1000);
        chk("R11 hit held", {31'd0, hit}, 1);
        data_phase(1, 0);
        addr_phase(32'h2000_0000, 4'b0110); settle();
        chk("R4 miss", {31'd0, hit}, 0);
        chk("R2 back-to-back", {31'd0, active}, 1);
        data_phase(1, 0);

        // Non-linear memory order: claim drops after the first phase
        addr_phase(32'h1000_0042, 4'b0110); settle();
        chk("R2 low bits cleared", cur_addr, 32'h1000_0040);
        chk("R6 no burst", {31'd0, burst}, 0);
        chk("R9 first phase claimed", {31'd0, hit}, 1);
        data_phase(0, 0); settle();
        chk("R9 claim dropped", {31'd0, hit}, 0);
        chk("R9 still active", {31'd0, active}, 1);
        data_phase(0, 0); settle();
        chk("R9 address held", cur_addr, 32'h1000_0040);
        bus_idle(); settle();
        chk("R9 drained", {31'd0, active}, 0);

        // I/O cycles: byte-level decode, fixed address
        addr_phase(32'h0000_03F9, 4'b0010); settle();
        chk("R3 io type", {29'd0, cyc_type}, 1);
        chk("R5 io hit", {31'd0, hit}, 1);
        data_phase(0, 0);
        data_phase(0, 0); settle();
        chk("R10 io address fixed", cur_addr, 32'h0000_03F9);
        data_phase(1, 0);
        bus_idle(); io_mask = 32'hFFFF_FFFF;
        addr_phase(32'h0000_03F9, 4'b0011); settle();
        chk("R5 io byte miss", {31'd0, hit}, 0);
        data_phase(1, 0);
        bus_idle(); io_mask = 32'hFFFF_FFF8;

        // Other command classes never hit
        addr_phase(32'h1000_0000, 4'b1010); settle();
        chk("R3 cfg type", {29'd0, cyc_type}, 3);
        chk("R5 cfg no hit", {31'd0, hit}, 0);
        data_phase(0, 0); settle();
        chk("R10 cfg address fixed", cur_addr, 32'h1000_0000);
        data_phase(1, 0);
        addr_phase(32'h0000_0000, 4'b0001); settle();
        chk("R3 special type", {29'd0, cyc_type}, 4);
        data_phase(1, 0);
        addr_phase(32'h1000_0000, 4'b0000); settle();
        chk("R3 other type 0000", {29'd0, cyc_type}, 5);
        data_phase(1, 0);
        addr_phase(32'h1000_0000, 4'b1100); settle();
        chk("R3 other type 1100", {29'd0, cyc_type}, 5);
        data_phase(1, 0);

        // Counter wraps at the top of the address space
        mem_base = 32'hFFFF_F000;
        addr_phase(32'hFFFF_FFFC, 4'b0110);
        data_phase(0, 0); settle();
        chk("R7 wrap", cur_addr, 32'h0000_0000);
        data_phase(1, 0);
        bus_idle();
        repeat (3) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule